// File: doc/BRIEF.md
# Filtered Event Counter Bank

This block is a small performance-monitoring unit that sits beside an address-translation engine. It holds a bank of event counters. Each counter is programmed with an event group number, a select mask of events within that group, and up to five optional attribute filters: requester ID, domain, PASID, ATS attribute and page-table attribute. Each clock the translation engine may present one event on the event inputs, qualified by `ev_valid`. The event carries its group number, a one-bit-per-event select vector and the attributes of the access that caused it. Every counter whose programming accepts the event advances by one.

Counters wrap silently at their fixed width, so software can always take deltas modulo 2^CNT_W. A wrap sets that counter's sticky bit in a write-one-to-clear overflow word and raises a single pending bit, which drives the interrupt line as a level. Each counter has its own enable bit. A global freeze bit stops every counter at once, and clearing it resumes counting from the held values. The event inputs are never back-pressured: an event with `ev_valid` high is seen in that cycle or not at all, and the block has no ready signal. Configuration goes through a plain register port. Writes take effect at the clock edge, and reads are combinational on `reg_addr`.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset every counter value, configuration word, enable bit, overflow status bit and the pending bit read as zero, `irq` is low and the unit is not frozen.
- R2: Register map: `reg_addr[ADDR_W-1]`=0 selects the counter given by the middle index bits. Its field is chosen by `reg_addr[2:0]`: 0 event config, 1 requester filter, 2 domain filter, 3 PASID filter, 4 ATS filter, 5 page-table filter, 6 count value, 7 enable in bit 0. With `reg_addr[ADDR_W-1]`=1, field 0 is the overflow word, 1 is the pending bit (bit 0) and 2 is the freeze bit (bit 0).
- R3: In the event config word, bits 27:0 are the select mask and bits 31:28 are the group. A counter accepts an event only when `ev_group` equals its group and `ev_sel` shares at least one set bit with its mask.
- R4: A counter with its enable bit at 0 never changes except by a direct write of its count field.
- R5: While the freeze bit is 1, no counter advances. Clearing it resumes counting from the unchanged values.
- R6: Each filter word holds its enable flag in bit 31 and its match value in the low bits (16 bits for requester ID and domain, 22 for PASID, 5 for ATS and page-table). A counter accepts an event only if every enabled filter equals the matching event attribute. A filter word written with zero matches everything.
- R7: A counter advances by at most one per clock.
- R8: A counter wraps from all-ones to zero without saturating.
- R9: The wrap sets that counter's bit in the overflow word. Writing 1 to a bit clears it, writing 0 leaves it. A wrap in the same cycle as the clear leaves the bit set.
- R10: Any wrap sets the pending bit. Writing 1 to bit 0 of the pending word clears it, and a wrap in the same cycle wins. `irq` equals the pending bit.
- R11: A write to a count field loads the written value. If an accepted event arrives in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_group | input | 4 | Event group number |
| ev_sel | input | 28 | One bit per event within the group |
| ev_rid | input | 16 | Requester ID of the access |
| ev_dom | input | 16 | Domain of the access |
| ev_pasid | input | 22 | PASID of the access |
| ev_ats | input | 5 | ATS attribute of the access |
| ev_pt | input | 5 | Page-table attribute of the access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 1 | Overflow interrupt level |

## Verification
The bench builds the bank with four counters of 8 bits. At that width a wrap is only a preload away, and the full reset state of every register can be read back. The main sweep drives every group number against every single select bit while four differently programmed counters listen. It covers group matching, mask matching, the per-counter enable and a requester filter in one pass. A second sweep of 64 events varies all five attributes so that each filter both hits and misses. Directed cases cover freeze, wrap, the overflow and pending clears, and same-cycle collisions of a clear or a load with an event.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int SEL_W   = 28;
  localparam int GRP_W   = 4;
  localparam int RID_W   = 16;
  localparam int DOM_W   = 16;
  localparam int PASID_W = 22;
  localparam int ATTR_W  = 5;
  localparam int FLT_EN  = 31;
  localparam int FIELD_W = 3;

  typedef enum logic [FIELD_W-1:0] {
    F_EVCFG = 3'd0, F_RID = 3'd1, F_DOM = 3'd2, F_PASID = 3'd3,
    F_ATS = 3'd4, F_PT = 3'd5, F_COUNT = 3'd6, F_ENABLE = 3'd7
  } cnt_field_e;

  typedef enum logic [FIELD_W-1:0] {
    G_OVF = 3'd0, G_PEND = 3'd1, G_FREEZE = 3'd2
  } glb_field_e;

  typedef struct packed {
    logic [RID_W-1:0]   rid;
    logic [DOM_W-1:0]   dom;
    logic [PASID_W-1:0] pasid;
    logic [ATTR_W-1:0]  ats;
    logic [ATTR_W-1:0]  pt;
  } ev_attr_t;
endpackage

// File: rtl/ecb_filter.sv
module ecb_filter #(
  parameter int W = 16
) (
  input  logic         en,
  input  logic [W-1:0] ref_val,
  input  logic [W-1:0] ev_val,
  output logic         pass
);
  assign pass = !en || (ref_val == ev_val);
endmodule

// File: rtl/ecb_counter.sv
module ecb_counter
  import ecb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [FIELD_W-1:0]  field,
  input  logic [31:0]         wdata,
  input  logic                freeze,
  input  logic                ev_valid,
  input  logic [GRP_W-1:0]    ev_group,
  input  logic [SEL_W-1:0]    ev_sel,
  input  ev_attr_t            ev_attr,
  output logic [CNT_W-1:0]    count,
  output logic                ovf_pulse,
  output logic [31:0]         rdata
);
  logic [SEL_W-1:0]   sel_mask;
  logic [GRP_W-1:0]   grp;
  logic               enable;
  logic               rid_en, dom_en, pasid_en, ats_en, pt_en;
  logic [RID_W-1:0]   rid_v;
  logic [DOM_W-1:0]   dom_v;
  logic [PASID_W-1:0] pasid_v;
  logic [ATTR_W-1:0]  ats_v, pt_v;
  logic [4:0]         pass;
  logic               hit, cnt_wr;

  ecb_filter #(.W(RID_W))   u_f_rid   (.en(rid_en),   .ref_val(rid_v),   .ev_val(ev_attr.rid),   .pass(pass[0]));
  ecb_filter #(.W(DOM_W))   u_f_dom   (.en(dom_en),   .ref_val(dom_v),   .ev_val(ev_attr.dom),   .pass(pass[1]));
  ecb_filter #(.W(PASID_W)) u_f_pasid (.en(pasid_en), .ref_val(pasid_v), .ev_val(ev_attr.pasid), .pass(pass[2]));
  ecb_filter #(.W(ATTR_W))  u_f_ats   (.en(ats_en),   .ref_val(ats_v),   .ev_val(ev_attr.ats),   .pass(pass[3]));
  ecb_filter #(.W(ATTR_W))  u_f_pt    (.en(pt_en),    .ref_val(pt_v),    .ev_val(ev_attr.pt),    .pass(pass[4]));

  assign cnt_wr    = cfg_we && (field == F_COUNT);
  assign hit       = ev_valid && enable && !freeze && (grp == ev_group) &&
                     (|(sel_mask & ev_sel)) && (&pass);
  assign ovf_pulse = hit && !cnt_wr && (&count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_mask <= '0; grp <= '0; enable <= 1'b0;
      rid_en <= 1'b0; dom_en <= 1'b0; pasid_en <= 1'b0; ats_en <= 1'b0; pt_en <= 1'b0;
      rid_v <= '0; dom_v <= '0; pasid_v <= '0; ats_v <= '0; pt_v <= '0;
    end else if (cfg_we) begin
      case (field)
        F_EVCFG:  begin sel_mask <= wdata[SEL_W-1:0]; grp <= wdata[31:32-GRP_W]; end
        F_RID:    begin rid_en <= wdata[FLT_EN];   rid_v <= wdata[RID_W-1:0]; end
        F_DOM:    begin dom_en <= wdata[FLT_EN];   dom_v <= wdata[DOM_W-1:0]; end
        F_PASID:  begin pasid_en <= wdata[FLT_EN]; pasid_v <= wdata[PASID_W-1:0]; end
        F_ATS:    begin ats_en <= wdata[FLT_EN];   ats_v <= wdata[ATTR_W-1:0]; end
        F_PT:     begin pt_en <= wdata[FLT_EN];    pt_v <= wdata[ATTR_W-1:0]; end
        F_ENABLE: enable <= wdata[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (cnt_wr) count <= wdata[CNT_W-1:0];
    else if (hit)    count <= count + 1'b1;
  end

  always_comb begin
    case (field)
      F_EVCFG:  rdata = {grp, sel_mask};
      F_RID:    rdata = {rid_en, 31'(rid_v)};
      F_DOM:    rdata = {dom_en, 31'(dom_v)};
      F_PASID:  rdata = {pasid_en, 31'(pasid_v)};
      F_ATS:    rdata = {ats_en, 31'(ats_v)};
      F_PT:     rdata = {pt_en, 31'(pt_v)};
      F_COUNT:  rdata = 32'(count);
      default:  rdata = {31'd0, enable};
    endcase
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count == $past(count)) || (count == $past(count) + 1'b1)); // R7
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cnt_wr) |=> $stable(count)); // R5
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !cnt_wr) |=> $stable(count)); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse) |=> (count == '0)); // R8
endmodule

// File: rtl/ecb_status.sv
module ecb_status #(
  parameter int NUM_CNT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] ovf_pulse,
  input  logic               clr_ovf_we,
  input  logic               clr_pend_we,
  input  logic [NUM_CNT-1:0] clr_bits,
  output logic [NUM_CNT-1:0] ovf_status,
  output logic               pending
);
  logic [NUM_CNT-1:0] clr_mask;
  assign clr_mask = clr_ovf_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_status <= '0;
      pending    <= 1'b0;
    end else begin
      ovf_status <= (ovf_status & ~clr_mask) | ovf_pulse;
      pending    <= (pending && !(clr_pend_we && clr_bits[0])) || (|ovf_pulse);
    end
  end

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_pulse) |=> ((ovf_status & $past(ovf_pulse)) == $past(ovf_pulse))); // R9
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf_we && ovf_pulse == '0) |=> ((ovf_status & $past(clr_bits)) == '0)); // R9
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_pulse) |=> pending); // R10
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import ecb_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
  localparam int ADDR_W = 1 + IDX_W + FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [3:0]        ev_group,
  input  logic [27:0]       ev_sel,
  input  logic [15:0]       ev_rid,
  input  logic [15:0]       ev_dom,
  input  logic [21:0]       ev_pasid,
  input  logic [4:0]        ev_ats,
  input  logic [4:0]        ev_pt,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic                 is_glb;
  logic [IDX_W-1:0]     idx;
  logic [FIELD_W-1:0]   field;
  logic                 frozen, pending;
  logic [NUM_CNT-1:0]   ovf_pulse, ovf_status;
  logic [31:0]          cnt_rdata [NUM_CNT];
  ev_attr_t             attr;

  assign is_glb = reg_addr[ADDR_W-1];
  assign idx    = reg_addr[FIELD_W +: IDX_W];
  assign field  = reg_addr[FIELD_W-1:0];
  assign attr   = '{rid: ev_rid, dom: ev_dom, pasid: ev_pasid, ats: ev_ats, pt: ev_pt};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt_val;
    ecb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(reg_we && !is_glb && (idx == IDX_W'(i))),
      .field(field), .wdata(reg_wdata), .freeze(frozen),
      .ev_valid(ev_valid), .ev_group(ev_group), .ev_sel(ev_sel), .ev_attr(attr),
      .count(cnt_val), .ovf_pulse(ovf_pulse[i]), .rdata(cnt_rdata[i]));
  end

  ecb_status #(.NUM_CNT(NUM_CNT)) u_status (
    .clk(clk), .rst_n(rst_n), .ovf_pulse(ovf_pulse),
    .clr_ovf_we(reg_we && is_glb && field == G_OVF),
    .clr_pend_we(reg_we && is_glb && field == G_PEND),
    .clr_bits(reg_wdata[NUM_CNT-1:0]),
    .ovf_status(ovf_status), .pending(pending));

  always_ff @(posedge clk) begin
    if (!rst_n) frozen <= 1'b0;
    else if (reg_we && is_glb && field == G_FREEZE) frozen <= reg_wdata[0];
  end

  assign irq = pending;

  always_comb begin
    reg_rdata = '0;
    if (is_glb) begin
      case (field)
        G_OVF:    reg_rdata = 32'(ovf_status);
        G_PEND:   reg_rdata = {31'd0, pending};
        G_FREEZE: reg_rdata = {31'd0, frozen};
        default:  reg_rdata = '0;
      endcase
    end else if (int'(idx) < NUM_CNT) begin
      reg_rdata = cnt_rdata[idx];
    end
  end

  AST_FROZEN_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> (ovf_pulse == '0)); // R5
endmodule

// File: tb/evt_counter_bank_test.sv
module evt_counter_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int CW = 8;
  localparam int AW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [3:0] ev_group = '0;
  logic [27:0] ev_sel = '0;
  logic [15:0] ev_rid = '0, ev_dom = '0;
  logic [21:0] ev_pasid = '0;
  logic [4:0] ev_ats = '0, ev_pt = '0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;

  evt_counter_bank #(.NUM_CNT(NC), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_group(ev_group), .ev_sel(ev_sel),
    .ev_rid(ev_rid), .ev_dom(ev_dom), .ev_pasid(ev_pasid), .ev_ats(ev_ats), .ev_pt(ev_pt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [3:0]    m_grp [NC];
  logic [27:0]   m_mask [NC];
  logic          m_en [NC];
  logic [31:0]   m_flt [NC][5];
  logic [CW-1:0] m_cnt [NC];
  logic          m_frz = 1'b0;

  function automatic logic [AW-1:0] cadr(int i, int f);
    return {1'b0, 2'(i), 3'(f)};
  endfunction
  function automatic logic [AW-1:0] gadr(int f);
    return {1'b1, 2'b00, 3'(f)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic cfg(int i, int g, logic [27:0] mask, logic en);
    wr(cadr(i, 0), {4'(g), mask}); wr(cadr(i, 7), {31'd0, en}); wr(cadr(i, 6), 32'd0);
    for (int f = 0; f < 5; f++) begin wr(cadr(i, f + 1), 32'd0); m_flt[i][f] = '0; end
    m_grp[i] = 4'(g); m_mask[i] = mask; m_en[i] = en; m_cnt[i] = '0;
  endtask

  task automatic set_flt(int i, int f, logic [31:0] v);
    wr(cadr(i, f + 1), v); m_flt[i][f] = v;
  endtask

  function automatic logic accept(int i, logic [3:0] g, logic [27:0] s, logic [15:0] r,
                                  logic [15:0] d, logic [21:0] p, logic [4:0] a, logic [4:0] t);
    logic ok;
    ok = m_en[i] && !m_frz && (m_grp[i] == g) && ((m_mask[i] & s) != 0);
    if (m_flt[i][0][31] && m_flt[i][0][15:0] != r) ok = 1'b0;
    if (m_flt[i][1][31] && m_flt[i][1][15:0] != d) ok = 1'b0;
    if (m_flt[i][2][31] && m_flt[i][2][21:0] != p) ok = 1'b0;
    if (m_flt[i][3][31] && m_flt[i][3][4:0] != a) ok = 1'b0;
    if (m_flt[i][4][31] && m_flt[i][4][4:0] != t) ok = 1'b0;
    return ok;
  endfunction

  task automatic fire(logic [3:0] g, logic [27:0] s, logic [15:0] r, logic [15:0] d,
                      logic [21:0] p, logic [4:0] a, logic [4:0] t);
    @(negedge clk);
    ev_valid = 1'b1; ev_group = g; ev_sel = s; ev_rid = r; ev_dom = d;
    ev_pasid = p; ev_ats = a; ev_pt = t;
    for (int i = 0; i < NC; i++) if (accept(i, g, s, r, d, p, a, t)) m_cnt[i] = m_cnt[i] + 1'b1;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic check_counts(string req);
    logic [31:0] d;
    for (int i = 0; i < NC; i++) begin rd(cadr(i, 6), d); check(req, d, 32'(m_cnt[i])); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every register
    for (int i = 0; i < NC; i++)
      for (int f = 0; f < 8; f++) begin rd(cadr(i, f), d); check("R1", d, 32'd0); end
    for (int f = 0; f < 3; f++) begin rd(gadr(f), d); check("R1", d, 32'd0); end
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R2/R3: field readback of config word (mask bits 27:0, group bits 31:28)
    cfg(0, 2, 28'h0000005, 1'b1);
    cfg(1, 15, 28'hFFFFFFF, 1'b1);
    cfg(2, 2, 28'h0000005, 1'b0);
    cfg(3, 2, 28'h0000005, 1'b1);
    set_flt(3, 0, 32'h8000_1234);
    rd(cadr(1, 0), d); check("R2 R3 cfg word", d, 32'hFFFF_FFFF);
    rd(cadr(3, 1), d); check("R2 R6 filter word", d, 32'h8000_1234);
    rd(cadr(0, 7), d); check("R2 enable", d, 32'd1);

    // R3 R4 R6 R7: sweep every group against every single select bit
    for (int g = 0; g < 16; g++)
      for (int s = 0; s < 28; s++)
        fire(4'(g), 28'(1) << s, (s == 2) ? 16'h1234 : 16'h0, 16'h0, 22'h0, 5'h0, 5'h0);
    check_counts("R3 R4 R6 R7 sweep");
    check("R4 disabled counter", 32'(m_cnt[2]), 32'd0);
    check("R3 all-mask counter", 32'(m_cnt[1]), 32'd28);
    rd(gadr(0), d); check("R9 no overflow", d, 32'd0);

    // R6: each filter type, hits and misses
    cfg(0, 0, 28'h1, 1'b1); set_flt(0, 1, 32'h8000_00AB);
    cfg(1, 0, 28'h1, 1'b1); set_flt(1, 2, 32'h802A_BCDE);
    cfg(2, 0, 28'h1, 1'b1); set_flt(2, 3, 32'h8000_0011);
    cfg(3, 0, 28'h1, 1'b1); set_flt(3, 4, 32'h8000_000A);
    for (int k = 0; k < 64; k++)
      fire(4'd0, 28'h1, 16'(k), (k % 4 == 0) ? 16'h00AB : 16'(k),
           (k % 3 == 0) ? 22'h2ABCDE : 22'(k), 5'(k), 5'(k));
    check_counts("R6 filters");
    set_flt(0, 1, 32'h0);
    fire(4'd0, 28'h1, 16'h0, 16'h5555, 22'h0, 5'h0, 5'h0);
    check_counts("R6 zero filter word");

    // R5: freeze and unfreeze
    wr(gadr(2), 32'd1); m_frz = 1'b1;
    rd(gadr(2), d); check("R5 freeze readback", d, 32'd1);
    for (int k = 0; k < 5; k++) fire(4'd0, 28'h1, 16'h0, 16'hAB, 22'h2ABCDE, 5'h11, 5'h0A);
    check_counts("R5 frozen");
    wr(gadr(2), 32'd0); m_frz = 1'b0;
    fire(4'd0, 28'h1, 16'h0, 16'hAB, 22'h2ABCDE, 5'h11, 5'h0A);
    check_counts("R5 resumed");

    // R8 R9 R10: wrap, overflow status, pending, clears
    cfg(0, 0, 28'h1, 1'b1); cfg(1, 0, 28'h0, 1'b1); cfg(2, 0, 28'h0, 1'b1); cfg(3, 0, 28'h0, 1'b1);
    wr(cadr(0, 6), 32'hFE); m_cnt[0] = 8'hFE;
    fire(4'd0, 28'h1, 16'h0, 16'h0, 22'h0, 5'h0, 5'h0);
    rd(gadr(0), d); check("R9 no ovf at all-ones", d, 32'd0);
    check("R10 irq low", {31'd0, irq}, 32'd0);
    fire(4'd0, 28'h1, 16'h0, 16'h0, 22'h0, 5'h0, 5'h0);
    check_counts("R8 wrap to zero");
    rd(gadr(0), d); check("R9 ovf set", d, 32'd1);
    rd(gadr(1), d); check("R10 pending set", d, 32'd1);
    check("R10 irq high", {31'd0, irq}, 32'd1);
    wr(gadr(0), 32'hE); rd(gadr(0), d); check("R9 write 0 keeps bit", d, 32'd1);
    wr(gadr(0), 32'h1); rd(gadr(0), d); check("R9 W1C", d, 32'd0);
    check("R10 pending survives ovf clear", {31'd0, irq}, 32'd1);
    wr(gadr(1), 32'h1); check("R10 irq cleared", {31'd0, irq}, 32'd0);

    // R9 R10: clear in the same cycle as a new wrap
    wr(cadr(0, 6), 32'hFF);
    fire(4'd0, 28'h1, 16'h0, 16'h0, 22'h0, 5'h0, 5'h0);
    wr(cadr(0, 6), 32'hFF);
    @(negedge clk); ev_valid = 1'b1; ev_group = 4'd0; ev_sel = 28'h1;
    reg_we = 1'b1; reg_addr = gadr(0); reg_wdata = 32'h1;
    @(negedge clk); ev_valid = 1'b0; reg_we = 1'b0;
    rd(gadr(0), d); check("R9 set wins over clear", d, 32'd1);
    wr(cadr(0, 6), 32'hFF);
    @(negedge clk); ev_valid = 1'b1;
    reg_we = 1'b1; reg_addr = gadr(1); reg_wdata = 32'h1;
    @(negedge clk); ev_valid = 1'b0; reg_we = 1'b0;
    #1; check("R10 set wins over clear", {31'd0, irq}, 32'd1);

    // R11: load wins over a same-cycle event
    @(negedge clk); ev_valid = 1'b1;
    reg_we = 1'b1; reg_addr = cadr(0, 6); reg_wdata = 32'h40;
    @(negedge clk); ev_valid = 1'b0; reg_we = 1'b0;
    rd(cadr(0, 6), d); check("R11 load wins", d, 32'h40);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule